// File: doc/BRIEF.md
# Configurable Dead-Time Generator

This block sits between a PWM comparator stage and the output pins of a half-bridge or full-bridge driver. It accepts two PWM streams, A and B, and produces two outputs in which selected edges are held back by a programmable number of ticks. Holding back edges creates a guard interval, so a high-side and a low-side switch are never driven on together.

Two delay units do the work. The rising-edge unit holds back low-to-high transitions of its chosen source and lets high-to-low transitions through at once. The falling-edge unit does the reverse. Each unit picks stream A or B as its source, and each unit's result can be inverted. Each output can skip the delay path and take its raw stream instead. A final swap stage can exchange the two outputs, or drive one onto both.

The configuration word and the two delay counts are loaded through a simple write port. Each write takes effect from the next clock. An optional external tick input can slow the delay counters down.

Top module: `deadtime_gen`

## Requirements
- R1: A write with `regWe` high is captured at the clock edge and acts from the next cycle. The address selects the register: 0 is the configuration word, 1 is the rising-edge delay, 2 is the falling-edge delay. Delays use the low `DELAY_W` data bits. After reset all three registers are zero.
- R2: After reset, with both inputs low, both outputs are low.
- R3: The rising-edge unit raises its result D+1 clocks after its source goes high, where D is the rising delay and the tick is always enabled. It lowers its result one clock after the source goes low. With D = 0 the unit is a single register stage.
- R4: The falling-edge unit lowers its result D+1 clocks after its source goes low, where D is the falling delay. It raises its result one clock after the source goes high.
- R5: Configuration bit 11 selects the rising-edge unit's source, and bit 12 selects the falling-edge unit's source. For each bit, 0 means stream A and 1 means stream B.
- R6: Configuration bit 13 inverts the rising-edge unit's result. Bit 14 inverts the falling-edge unit's result.
- R7: Configuration bit 15 drives output path A straight from stream A. Bit 16 drives output path B straight from stream B. A bypassed path adds no delay and no register.
- R8: With bits 9 and 10 both set, the outputs are exchanged. With only bit 9 set, both outputs carry path B. With only bit 10 set, both outputs carry path A. Otherwise output A carries path A and output B carries path B. Path A is the bypassed stream or the inverted rising-edge result. Path B is the bypassed stream or the inverted falling-edge result.
- R9: With configuration bit 17 clear, the delay counters advance on every clock. With bit 17 set, they advance only in cycles where `tickIn` is high.
- R10: A source pulse shorter than the programmed delay leaves the delayed result unchanged.
- R11: With only bit 14 set (complementary active-high), once that setting has been held for one cycle, `outA` and `outB` are never high together.
- R12: Configuration bits 8 down to 0 have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 config, 1 rising delay, 2 falling delay) |
| regWdata | input | max(18, DELAY_W) | Register write data |
| tickIn | input | 1 | External counter tick, used when bit 17 is set |
| pwmA | input | 1 | PWM stream A |
| pwmB | input | 1 | PWM stream B |
| outA | output | 1 | Output A |
| outB | output | 1 | Output B |

## Verification
The bench builds the block with the default `DELAY_W` of 16 and loads only small delay counts, from 0 to 7. Every held-back edge therefore lands within a few clocks, where exact latencies can be counted. Pulses shorter than the delay, gating by a stalled tick, and the zero-delay single-register case all fit in short runs. The full 18-bit configuration space is reached by random writes, which exercise every swap, bypass, invert and select combination against a cycle model.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  // Configuration word layout (bit positions are decoded by dtg_ctrl)
  localparam int CFG_W        = 18;
  localparam int BIT_TICKSEL  = 17;
  localparam int BIT_BYPB     = 16;
  localparam int BIT_BYPA     = 15;
  localparam int BIT_FEDINV   = 14;
  localparam int BIT_REDINV   = 13;
  localparam int BIT_FEDSRC   = 12;
  localparam int BIT_REDSRC   = 11;
  localparam int BIT_SWAPB    = 10;
  localparam int BIT_SWAPA    = 9;
  localparam int CFG_LO       = BIT_SWAPA;

  localparam logic [1:0] ADDR_CFG = 2'd0;
  localparam logic [1:0] ADDR_RED = 2'd1;
  localparam logic [1:0] ADDR_FED = 2'd2;

  // Decoded strobes from control to datapath
  typedef struct packed {
    logic tick;
    logic redFromB;
    logic fedFromB;
    logic redInv;
    logic fedInv;
    logic bypassA;
    logic bypassB;
    logic swapA;
    logic swapB;
  } dtgCtl_t;
endpackage

// File: rtl/dtg_edge_delay.sv
module dtg_edge_delay #(
  parameter int DW         = 16,
  parameter bit DELAY_RISE = 1'b1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tickEn,
  input  logic          sigIn,
  input  logic [DW-1:0] delay,
  output logic          sigOut
);
  // Work on the "active" level: the level whose arrival is held back.
  localparam bit RESET_HELD = !DELAY_RISE;

  logic          activeIn;
  logic          heldQ;
  logic [DW-1:0] cntQ;

  assign activeIn = DELAY_RISE ? sigIn : ~sigIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldQ <= RESET_HELD;
      cntQ  <= '0;
    end else if (!activeIn) begin
      heldQ <= 1'b0;
      cntQ  <= '0;
    end else if (!heldQ) begin
      if (cntQ >= delay) heldQ <= 1'b1;
      else if (tickEn)   cntQ  <= cntQ + 1'b1;
    end
  end

  assign sigOut = DELAY_RISE ? heldQ : ~heldQ;

  // R3 / R4: the non-delayed edge passes after one register
  assert_edge_pass_R3: assert property (@(posedge clk) disable iff (!rstN)
    !activeIn |=> !heldQ);
  // R3 / R4: the delayed level only appears while the source holds it
  assert_rise_needs_src_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(heldQ) |-> $past(activeIn));
  // R3: zero delay is a single register stage
  assert_zero_delay_R3: assert property (@(posedge clk) disable iff (!rstN)
    (activeIn && !heldQ && delay == '0) |=> heldQ);
  // R9: without a tick the counter never advances
  assert_hold_no_tick_R9: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> (cntQ <= $past(cntQ)));
endmodule

// File: rtl/dtg_ctrl.sv
module dtg_ctrl
  import dtg_pkg::*;
#(
  parameter int DW = 16,
  parameter int WW = 18
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWe,
  input  logic [1:0]    regAddr,
  input  logic [WW-1:0] regWdata,
  input  logic          tickIn,
  output dtgCtl_t       ctl,
  output logic [DW-1:0] redDelay,
  output logic [DW-1:0] fedDelay
);
  logic [CFG_W-1:CFG_LO] cfgQ;
  logic [DW-1:0]         redQ;
  logic [DW-1:0]         fedQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
      redQ <= '0;
      fedQ <= '0;
    end else if (regWe) begin
      case (regAddr)
        ADDR_CFG: cfgQ <= regWdata[CFG_W-1:CFG_LO];
        ADDR_RED: redQ <= regWdata[DW-1:0];
        ADDR_FED: fedQ <= regWdata[DW-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    ctl.tick     = cfgQ[BIT_TICKSEL] ? tickIn : 1'b1;
    ctl.redFromB = cfgQ[BIT_REDSRC];
    ctl.fedFromB = cfgQ[BIT_FEDSRC];
    ctl.redInv   = cfgQ[BIT_REDINV];
    ctl.fedInv   = cfgQ[BIT_FEDINV];
    ctl.bypassA  = cfgQ[BIT_BYPA];
    ctl.bypassB  = cfgQ[BIT_BYPB];
    ctl.swapA    = cfgQ[BIT_SWAPA];
    ctl.swapB    = cfgQ[BIT_SWAPB];
  end

  assign redDelay = redQ;
  assign fedDelay = fedQ;

  // R1: a configuration write is visible on the next cycle
  assert_cfg_write_R1: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADDR_CFG) |=> (cfgQ == $past(regWdata[CFG_W-1:CFG_LO])));
endmodule

// File: rtl/dtg_datapath.sv
module dtg_datapath
  import dtg_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  dtgCtl_t       ctl,
  input  logic [DW-1:0] redDelay,
  input  logic [DW-1:0] fedDelay,
  input  logic          pwmA,
  input  logic          pwmB,
  output logic          outA,
  output logic          outB
);
  localparam int N_UNITS = 2;  // 0: rising-edge unit, 1: falling-edge unit

  logic [N_UNITS-1:0] unitSrc;
  logic [N_UNITS-1:0] unitOut;
  logic [DW-1:0]      unitDelay [N_UNITS];
  logic               pathA;
  logic               pathB;

  assign unitSrc[0]   = ctl.redFromB ? pwmB : pwmA;
  assign unitSrc[1]   = ctl.fedFromB ? pwmB : pwmA;
  assign unitDelay[0] = redDelay;
  assign unitDelay[1] = fedDelay;

  for (genvar g = 0; g < N_UNITS; g++) begin : gUnit
    dtg_edge_delay #(
      .DW        (DW),
      .DELAY_RISE(g == 0)
    ) edgeDly_i (
      .clk   (clk),
      .rstN  (rstN),
      .tickEn(ctl.tick),
      .sigIn (unitSrc[g]),
      .delay (unitDelay[g]),
      .sigOut(unitOut[g])
    );
  end

  assign pathA = ctl.bypassA ? pwmA : (unitOut[0] ^ ctl.redInv);
  assign pathB = ctl.bypassB ? pwmB : (unitOut[1] ^ ctl.fedInv);

  always_comb begin
    case ({ctl.swapA, ctl.swapB})
      2'b11:   begin outA = pathB; outB = pathA; end
      2'b10:   begin outA = pathB; outB = pathB; end
      2'b01:   begin outA = pathA; outB = pathA; end
      default: begin outA = pathA; outB = pathB; end
    endcase
  end
endmodule

// File: rtl/deadtime_gen.sv
module deadtime_gen
  import dtg_pkg::*;
#(
  parameter int DELAY_W = 16,
  localparam int WDATA_W = (DELAY_W > CFG_W) ? DELAY_W : CFG_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [1:0]         regAddr,
  input  logic [WDATA_W-1:0] regWdata,
  input  logic               tickIn,
  input  logic               pwmA,
  input  logic               pwmB,
  output logic               outA,
  output logic               outB
);
  dtgCtl_t              ctl;
  logic [DELAY_W-1:0]   redDelay;
  logic [DELAY_W-1:0]   fedDelay;

  dtg_ctrl #(.DW(DELAY_W), .WW(WDATA_W)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .regWe   (regWe),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .tickIn  (tickIn),
    .ctl     (ctl),
    .redDelay(redDelay),
    .fedDelay(fedDelay)
  );

  dtg_datapath #(.DW(DELAY_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .redDelay(redDelay),
    .fedDelay(fedDelay),
    .pwmA    (pwmA),
    .pwmB    (pwmB),
    .outA    (outA),
    .outB    (outB)
  );

  // R11: complementary active-high setting never drives both outputs
  logic isCompl;
  assign isCompl = ctl.fedInv && !ctl.redInv && !ctl.bypassA && !ctl.bypassB &&
                   !ctl.redFromB && !ctl.fedFromB && !ctl.swapA && !ctl.swapB;

  assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rstN)
    (isCompl && $past(isCompl)) |-> !(outA && outB));
endmodule

// File: tb/deadtime_gen_tb_top.sv
module deadtime_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int WW = 18;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWe = 1'b0;
  logic [1:0]    regAddr = '0;
  logic [WW-1:0] regWdata = '0;
  logic          tickIn = 1'b0;
  logic          pwmA = 1'b0;
  logic          pwmB = 1'b0;
  logic          outA;
  logic          outB;

  int    nChecks = 0;
  int    nFails = 0;
  string phaseTag = "R2";
  bit    cmpOn = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  deadtime_gen #(.DELAY_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .tickIn(tickIn), .pwmA(pwmA), .pwmB(pwmB),
    .outA(outA), .outB(outB)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [17:0] mCfg;
  int mRed, mFed, rCnt, fCnt;
  bit rLvl, fLvl;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCfg = '0; mRed = 0; mFed = 0; rCnt = 0; fCnt = 0; rLvl = 0; fLvl = 0;
    end else begin
      bit tk, srcR, srcF;
      tk   = mCfg[17] ? tickIn : 1'b1;
      srcR = mCfg[11] ? pwmB : pwmA;
      srcF = mCfg[12] ? pwmB : pwmA;
      if (!srcR) begin rLvl = 0; rCnt = 0; end
      else if (!rLvl) begin
        if (rCnt >= mRed) rLvl = 1;
        else if (tk) rCnt = rCnt + 1;
      end
      if (srcF) begin fLvl = 1; fCnt = 0; end
      else if (fLvl) begin
        if (fCnt >= mFed) fLvl = 0;
        else if (tk) fCnt = fCnt + 1;
      end
      if (regWe) begin
        if (regAddr == 2'd0) mCfg = regWdata;
        else if (regAddr == 2'd1) mRed = int'(regWdata[DW-1:0]);
        else if (regAddr == 2'd2) mFed = int'(regWdata[DW-1:0]);
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (rstN && cmpOn) begin
      bit pA, pB, eA, eB;
      pA = mCfg[15] ? pwmA : (rLvl ^ mCfg[13]);
      pB = mCfg[16] ? pwmB : (fLvl ^ mCfg[14]);
      case ({mCfg[9], mCfg[10]})
        2'b11:   begin eA = pB; eB = pA; end
        2'b10:   begin eA = pB; eB = pB; end
        2'b01:   begin eA = pA; eB = pA; end
        default: begin eA = pA; eB = pB; end
      endcase
      check({outA, outB} === {eA, eB}, phaseTag, "model compare",
            int'({outA, outB}), int'({eA, eB}));
    end
  end

  task automatic regWrite(input logic [1:0] a, input logic [WW-1:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic waitLevel(input bit onA, input bit lvl, output int n);
    n = 0;
    do begin
      @(negedge clk); #1; n++;
    end while ((onA ? outA : outB) !== lvl && n < 40);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    int n, hi, hiA, hiB;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(outA === 1'b0 && outB === 1'b0, "R2", "reset outputs",
          int'({outA, outB}), 0);
    cmpOn = 1'b1;

    // R1 + R3: rising delay 3 -> rise after 4 clocks
    phaseTag = "R3";
    regWrite(2'd1, 18'd3);
    @(negedge clk); pwmA = 1'b1;
    waitLevel(1'b1, 1'b1, n);
    check(n == 4, "R3", "rising latency D=3 (R1 write)", n, 4);
    repeat (2) @(negedge clk);
    pwmA = 1'b0;
    waitLevel(1'b1, 1'b0, n);
    check(n == 1, "R3", "falling passes", n, 1);

    // R4: falling delay 2
    phaseTag = "R4";
    regWrite(2'd2, 18'd2);
    @(negedge clk); pwmA = 1'b1;
    waitLevel(1'b0, 1'b1, n);
    check(n == 1, "R4", "rising passes", n, 1);
    repeat (3) @(negedge clk);
    pwmA = 1'b0;
    waitLevel(1'b0, 1'b0, n);
    check(n == 3, "R4", "falling latency D=2", n, 3);

    // R10: pulse shorter than delay absorbed
    phaseTag = "R10";
    regWrite(2'd1, 18'd5);
    @(negedge clk); pwmA = 1'b1;
    repeat (3) @(negedge clk);
    pwmA = 1'b0;
    hi = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); #1; if (outA) hi++; end
    check(hi == 0, "R10", "short pulse high cycles", hi, 0);

    // R5: sources from B
    phaseTag = "R5";
    regWrite(2'd1, 18'd0);
    regWrite(2'd0, 18'(1 << 11) | 18'(1 << 12));
    @(negedge clk); pwmA = 1'b1; pwmB = 1'b0;
    repeat (3) @(negedge clk); #1;
    check(outA === 1'b0 && outB === 1'b0, "R5", "A ignored when B selected",
          int'({outA, outB}), 0);
    @(negedge clk); pwmB = 1'b1;
    waitLevel(1'b1, 1'b1, n);
    check(n == 1, "R5", "B drives rising unit", n, 1);
    @(negedge clk); pwmA = 1'b0; pwmB = 1'b0;

    // R6: inversion of both units
    phaseTag = "R6";
    regWrite(2'd0, 18'(1 << 13) | 18'(1 << 14));
    repeat (4) @(negedge clk); #1;
    check(outA === 1'b1 && outB === 1'b1, "R6", "inverted low source",
          int'({outA, outB}), 3);

    // R7: bypass, same-cycle response
    phaseTag = "R7";
    regWrite(2'd0, 18'(3 << 15));
    @(negedge clk); pwmA = 1'b1; pwmB = 1'b0; #1;
    check(outA === 1'b1 && outB === 1'b0, "R7", "bypass A=1 B=0",
          int'({outA, outB}), 2);
    @(negedge clk); pwmA = 1'b0; pwmB = 1'b1; #1;
    check(outA === 1'b0 && outB === 1'b1, "R7", "bypass A=0 B=1",
          int'({outA, outB}), 1);

    // R8: swap variants on bypassed paths (A=1, B=0)
    phaseTag = "R8";
    @(negedge clk); pwmA = 1'b1; pwmB = 1'b0;
    regWrite(2'd0, 18'(3 << 15) | 18'(3 << 9));
    #1;
    check(outA === 1'b0 && outB === 1'b1, "R8", "both swap exchanges",
          int'({outA, outB}), 1);
    regWrite(2'd0, 18'(3 << 15) | 18'(1 << 9));
    #1;
    check(outA === 1'b0 && outB === 1'b0, "R8", "swap A copies path B",
          int'({outA, outB}), 0);
    regWrite(2'd0, 18'(3 << 15) | 18'(1 << 10));
    #1;
    check(outA === 1'b1 && outB === 1'b1, "R8", "swap B copies path A",
          int'({outA, outB}), 3);

    // R9: tick gating
    phaseTag = "R9";
    @(negedge clk); pwmA = 1'b0; pwmB = 1'b0;
    regWrite(2'd1, 18'd2);
    regWrite(2'd0, 18'(1 << 17));
    tickIn = 1'b0;
    @(negedge clk); pwmA = 1'b1;
    hi = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); #1; if (outA) hi++; end
    check(hi == 0, "R9", "no tick holds output", hi, 0);
    tickIn = 1'b1;
    waitLevel(1'b1, 1'b1, n);
    check(n == 3, "R9", "latency once ticking", n, 3);
    tickIn = 1'b0;
    regWrite(2'd0, 18'd0);
    @(negedge clk); pwmA = 1'b0;
    @(negedge clk); pwmA = 1'b1;
    waitLevel(1'b1, 1'b1, n);
    check(n == 3, "R9", "forced tick with bit 17 clear", n, 3);

    // R11: complementary active-high
    phaseTag = "R11";
    regWrite(2'd1, 18'd4);
    regWrite(2'd2, 18'd4);
    regWrite(2'd0, 18'(1 << 14));
    hi = 0; hiA = 0; hiB = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 7) == 0) pwmA = ~pwmA;
      #1;
      if (outA && outB) hi++;
      if (outA) hiA++;
      if (outB) hiB++;
    end
    check(hi == 0, "R11", "overlap cycles", hi, 0);
    check(hiA > 0 && hiB > 0, "R11", "both outputs active", hiA * hiB > 0, 1);

    // R12: low bits ignored
    phaseTag = "R12";
    regWrite(2'd1, 18'd0);
    regWrite(2'd2, 18'd0);
    regWrite(2'd0, 18'h001FF);
    @(negedge clk); pwmA = 1'b1; pwmB = 1'b0;
    repeat (2) @(negedge clk); #1;
    check(outA === 1'b1 && outB === 1'b1, "R12", "A high through both units",
          int'({outA, outB}), 3);
    @(negedge clk); pwmA = 1'b0;
    @(negedge clk); #1;
    check(outA === 1'b0 && outB === 1'b0, "R12", "A low through both units",
          int'({outA, outB}), 0);

    // Random configurations against the model
    phaseTag = "R1";
    for (int i = 0; i < 3000; i++) begin
      if (i % 150 == 0) begin
        regWrite(2'd1, 18'($urandom_range(0, 7)));
        regWrite(2'd2, 18'($urandom_range(0, 7)));
        regWrite(2'd0, 18'($urandom));
      end
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) pwmA = ~pwmA;
      if ($urandom_range(0, 3) == 0) pwmB = ~pwmB;
      tickIn = 1'($urandom);
    end

    @(negedge clk);
    cmpOn = 1'b0;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule